// File: doc/BRIEF.md
# Privileged Debug Register File

This block stores the breakpoint state of a processor core: four breakpoint linear addresses, one status word and one control word. Software reaches them through a single register-move port that carries a 3-bit register index. Two spare index values act as second names for the status and control words. The block compares the current privilege level against ring 0 on every access. An access from any other ring changes nothing and raises a protection-fault flag instead.

Two hardware inputs act on the stored state. A task-switch pulse clears the per-task (local) breakpoint enables and keeps the all-task (global) enables. A breakpoint matcher sends per-breakpoint hit pulses that set the matching status bits. Only software clears those bits. The control word and the four addresses are driven out continuously for the matcher to use.

Top module: `dbgreg_ctrl`

## Requirements
- R1: After reset every stored word is zero: ctrl_word, bp_addr_flat and the read data of all eight indices.
- R2: Indices 0 to 3 each hold a 32-bit breakpoint address. A privileged write to one of them appears on bp_addr_flat (index n at bits 32n+31:32n) on the next cycle, and reads of that index return it.
- R3: gp_fault is high in the same cycle, and only in that cycle, when acc_valid is high and cur_priv is not 0.
- R4: A faulted access, whether read or write and at any index, changes no stored state and returns zero on acc_rdata.
- R5: Index 4 reads and writes the status word exactly like index 6. Index 5 reads and writes the control word exactly like index 7.
- R6: A task_switch pulse clears control bits 0, 2, 4 and 6 on the next cycle and keeps every other bit. If a control write happens in the same cycle, the written value is used with those four bits forced to 0.
- R7: A hit_set[n] pulse sets status bit n on the next cycle. If a status write happens in the same cycle, the hit still sets its bit.
- R8: Status bits change only through hit_set or a privileged write to index 6 or 4, which loads wdata bits 3:0. Writing zero clears them. Status bits 31:4 always read as zero.
- R9: A privileged read (acc_valid=1, acc_write=0) returns the stored word combinationally in the same cycle. When no read is granted, acc_rdata is zero.
- R10: A privileged write to index 7 loads all 32 bits of the control word, and ctrl_word shows it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | Register-move access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_index | input | 3 | Register index 0..7 |
| acc_wdata | input | 32 | Write data |
| cur_priv | input | 2 | Current privilege level, 0 = most privileged |
| task_switch | input | 1 | One-cycle task-switch pulse |
| hit_set | input | 4 | Per-breakpoint hit pulses from the matcher |
| acc_rdata | output | 32 | Read data, same cycle as the access |
| gp_fault | output | 1 | Access refused because of privilege |
| ctrl_word | output | 32 | Current control word |
| bp_addr_flat | output | 128 | The four breakpoint addresses, index 0 in the low bits |

## Verification
Three results appear in the same cycle as their stimulus: acc_rdata, gp_fault and the reads through the alias indices. Writes, task-switch clears and hit sets show up one clock later on ctrl_word, bp_addr_flat and in later reads. The bench drives each stimulus on a falling edge and compares the combinational outputs one nanosecond later, against a model that still holds the old state. It then applies the model update only after the next rising edge, so every registered result is checked in the following cycle's compare. The model is updated in the order write, then task-switch mask, then hit OR. This order gives the expected outcome when a write and a task switch or a hit arrive in the same cycle.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM_BP = 4;
  localparam int unsigned IDX_W  = 3;

  localparam logic [IDX_W-1:0] IDX_STAT = 3'd6;
  localparam logic [IDX_W-1:0] IDX_CTRL = 3'd7;
  localparam logic [IDX_W-1:0] IDX_STAT_ALT = 3'd4;
  localparam logic [IDX_W-1:0] IDX_CTRL_ALT = 3'd5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  // Fold the two legacy indices onto their canonical targets.
  function automatic logic [IDX_W-1:0] canon_index(input logic [IDX_W-1:0] raw);
    logic [IDX_W-1:0] res;
    case (raw)
      IDX_STAT_ALT: res = IDX_STAT;
      IDX_CTRL_ALT: res = IDX_CTRL;
      default:      res = raw;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/dbgreg_access.sv
module dbgreg_access
  import dbgreg_pkg::*;
#(
  parameter int unsigned N_BP = NUM_BP
) (
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [IDX_W-1:0]          acc_index,
  input  logic [1:0]                cur_priv,
  output logic                      fault,
  output logic                      rd_grant,
  output logic                      wr_grant,
  output sel_e                      sel,
  output logic [$clog2(N_BP)-1:0]   bp_sel
);
  localparam int unsigned SEL_W = $clog2(N_BP);
  localparam logic [IDX_W-1:0] BP_LIMIT = IDX_W'(N_BP);

  logic [IDX_W-1:0] canon;
  logic             priv_ok;

  always_comb begin
    canon    = canon_index(acc_index);
    priv_ok  = (cur_priv == 2'd0);
    fault    = acc_valid & ~priv_ok;
    rd_grant = acc_valid & priv_ok & ~acc_write;
    wr_grant = acc_valid & priv_ok & acc_write;
    bp_sel   = canon[SEL_W-1:0];
    if (canon < BP_LIMIT)        sel = SEL_ADDR;
    else if (canon == IDX_STAT)  sel = SEL_STAT;
    else if (canon == IDX_CTRL)  sel = SEL_CTRL;
    else                         sel = SEL_NONE;
  end
endmodule

// File: rtl/dbgreg_bpaddr.sv
module dbgreg_bpaddr
  import dbgreg_pkg::*;
#(
  parameter int unsigned N_BP = NUM_BP,
  parameter int unsigned DW   = DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(N_BP)-1:0] bp_sel,
  input  logic [DW-1:0]           wdata,
  output logic [N_BP*DW-1:0]      addr_flat
);
  localparam int unsigned SEL_W = $clog2(N_BP);

  for (genvar i = 0; i < N_BP; i++) begin : g_slot
    logic          en;
    logic [DW-1:0] d;
    logic [DW-1:0] q;

    always_comb begin
      en = wr_en & (bp_sel == SEL_W'(i));
      d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign addr_flat[i*DW +: DW] = q;
  end
endmodule

// File: rtl/dbgreg_status.sv
module dbgreg_status
  import dbgreg_pkg::*;
#(
  parameter int unsigned N_BP = NUM_BP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [N_BP-1:0] wdata,
  input  logic [N_BP-1:0] hit_set,
  output logic [N_BP-1:0] status_q
);
  logic            en;
  logic [N_BP-1:0] d;

  // Software load first, then hardware hits OR in so no event is lost.
  always_comb begin
    en = wr_en | (|hit_set);
    d  = (wr_en ? wdata : status_q) | hit_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  status_q <= '0;
    else if (en) status_q <= d;
  end
endmodule

// File: rtl/dbgreg_control.sv
module dbgreg_control
  import dbgreg_pkg::*;
#(
  parameter int unsigned N_BP = NUM_BP,
  parameter int unsigned DW   = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          task_switch,
  output logic [DW-1:0] ctrl_q
);
  logic [DW-1:0] local_mask;
  logic [DW-1:0] base;
  logic [DW-1:0] d;
  logic          en;

  // Local enables sit on the even bits of the low byte pairs.
  always_comb begin
    local_mask = '0;
    for (int i = 0; i < int'(N_BP); i++) local_mask[2*i] = 1'b1;
  end

  always_comb begin
    en   = wr_en | task_switch;
    base = wr_en ? wdata : ctrl_q;
    d    = task_switch ? (base & ~local_mask) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (en) ctrl_q <= d;
  end
endmodule

// File: rtl/dbgreg_ctrl.sv
module dbgreg_ctrl
  import dbgreg_pkg::*;
#(
  parameter int unsigned N_BP = NUM_BP,
  parameter int unsigned DW   = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [IDX_W-1:0]    acc_index,
  input  logic [DW-1:0]       acc_wdata,
  input  logic [1:0]          cur_priv,
  input  logic                task_switch,
  input  logic [N_BP-1:0]     hit_set,
  output logic [DW-1:0]       acc_rdata,
  output logic                gp_fault,
  output logic [DW-1:0]       ctrl_word,
  output logic [N_BP*DW-1:0]  bp_addr_flat
);
  localparam int unsigned SEL_W = $clog2(N_BP);

  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic            rd_grant;
  logic            wr_grant;
  sel_e            sel;
  logic [SEL_W-1:0] bp_sel;
  logic            wr_addr;
  logic            wr_stat;
  logic            wr_ctrl;
  logic [N_BP-1:0] status_q;
  logic [DW-1:0]   addr_arr [N_BP];

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dbgreg_access #(.N_BP(N_BP)) u_access (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_index (acc_index),
    .cur_priv  (cur_priv),
    .fault     (gp_fault),
    .rd_grant  (rd_grant),
    .wr_grant  (wr_grant),
    .sel       (sel),
    .bp_sel    (bp_sel)
  );

  always_comb begin
    wr_addr = wr_grant & (sel == SEL_ADDR);
    wr_stat = wr_grant & (sel == SEL_STAT);
    wr_ctrl = wr_grant & (sel == SEL_CTRL);
  end

  dbgreg_bpaddr #(.N_BP(N_BP), .DW(DW)) u_bpaddr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_addr),
    .bp_sel    (bp_sel),
    .wdata     (acc_wdata),
    .addr_flat (bp_addr_flat)
  );

  dbgreg_status #(.N_BP(N_BP)) u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_stat),
    .wdata    (acc_wdata[N_BP-1:0]),
    .hit_set  (hit_set),
    .status_q (status_q)
  );

  dbgreg_control #(.N_BP(N_BP), .DW(DW)) u_control (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_ctrl),
    .wdata       (acc_wdata),
    .task_switch (task_switch),
    .ctrl_q      (ctrl_word)
  );

  for (genvar i = 0; i < N_BP; i++) begin : g_unpack
    assign addr_arr[i] = bp_addr_flat[i*DW +: DW];
  end

  always_comb begin
    acc_rdata = '0;
    if (rd_grant) begin
      case (sel)
        SEL_ADDR: acc_rdata = addr_arr[bp_sel];
        SEL_STAT: acc_rdata = DW'(status_q);
        SEL_CTRL: acc_rdata = ctrl_word;
        default:  acc_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dbgreg_checker.sv
module dbgreg_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         acc_valid,
  input logic         acc_write,
  input logic [2:0]   acc_index,
  input logic [1:0]   cur_priv,
  input logic         task_switch,
  input logic [3:0]   hit_set,
  input logic [31:0]  acc_rdata,
  input logic         gp_fault,
  input logic [31:0]  ctrl_word,
  input logic [127:0] bp_addr_flat,
  input logic [3:0]   status_q
);
  logic stat_wr;
  assign stat_wr = acc_valid & acc_write & (cur_priv == 2'd0) &
                   ((acc_index == 3'd6) | (acc_index == 3'd4));

  assert_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && cur_priv != 2'd0) |-> gp_fault);
  assert_no_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && cur_priv != 2'd0) |-> !gp_fault);
  assert_fault_rdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |-> acc_rdata == 32'h0);
  assert_fault_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gp_fault |=> $stable(bp_addr_flat));
  assert_fault_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_fault && !task_switch) |=> $stable(ctrl_word));
  assert_tsw_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> (ctrl_word & 32'h55) == 32'h0);
  assert_hit_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_set != 4'h0) |=> (status_q & $past(hit_set)) == $past(hit_set));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> (status_q & $past(status_q)) == $past(status_q));
endmodule

bind dbgreg_ctrl dbgreg_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .acc_valid    (acc_valid),
  .acc_write    (acc_write),
  .acc_index    (acc_index),
  .cur_priv     (cur_priv),
  .task_switch  (task_switch),
  .hit_set      (hit_set),
  .acc_rdata    (acc_rdata),
  .gp_fault     (gp_fault),
  .ctrl_word    (ctrl_word),
  .bp_addr_flat (bp_addr_flat),
  .status_q     (status_q)
);

// File: tb/sim_dbgreg_ctrl.sv
`timescale 1ns/1ps
module sim_dbgreg_ctrl;
  logic         clk;
  logic         rst_n;
  logic         acc_valid;
  logic         acc_write;
  logic [2:0]   acc_index;
  logic [31:0]  acc_wdata;
  logic [1:0]   cur_priv;
  logic         task_switch;
  logic [3:0]   hit_set;
  logic [31:0]  acc_rdata;
  logic         gp_fault;
  logic [31:0]  ctrl_word;
  logic [127:0] bp_addr_flat;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  logic [31:0] m_addr [4];
  logic [3:0]  m_st;
  logic [31:0] m_ctl;

  dbgreg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_index(acc_index), .acc_wdata(acc_wdata), .cur_priv(cur_priv),
    .task_switch(task_switch), .hit_set(hit_set), .acc_rdata(acc_rdata),
    .gp_fault(gp_fault), .ctrl_word(ctrl_word), .bp_addr_flat(bp_addr_flat)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input logic [2:0] idx);
    logic [2:0] e;
    e = (idx == 3'd4) ? 3'd6 : (idx == 3'd5) ? 3'd7 : idx;
    if (e < 3'd4)       return m_addr[e[1:0]];
    else if (e == 3'd6) return {28'h0, m_st};
    else if (e == 3'd7) return m_ctl;
    return 32'h0;
  endfunction

  // Drive at the falling edge, compare, then advance the model past the rising edge.
  task automatic step(input logic v, input logic w, input logic [2:0] idx,
                      input logic [31:0] wd, input logic [1:0] pr,
                      input logic ts, input logic [3:0] hs, input string tag);
    logic ok;
    logic [2:0] e;
    acc_valid = v; acc_write = w; acc_index = idx; acc_wdata = wd;
    cur_priv = pr; task_switch = ts; hit_set = hs;
    #1;
    ok = v && (pr == 2'd0);
    check(tag, "acc_rdata", {96'h0, acc_rdata},
          {96'h0, (ok && !w) ? model_word(idx) : 32'h0});
    check(tag, "gp_fault", {127'h0, gp_fault}, {127'h0, v && (pr != 2'd0)});
    check(tag, "ctrl_word", {96'h0, ctrl_word}, {96'h0, m_ctl});
    check(tag, "bp_addr_flat", bp_addr_flat,
          {m_addr[3], m_addr[2], m_addr[1], m_addr[0]});
    @(posedge clk);
    e = (idx == 3'd4) ? 3'd6 : (idx == 3'd5) ? 3'd7 : idx;
    if (ok && w) begin
      if (e < 3'd4)       m_addr[e[1:0]] = wd;
      else if (e == 3'd6) m_st = wd[3:0];
      else if (e == 3'd7) m_ctl = wd;
    end
    if (ts) m_ctl = m_ctl & ~32'h55;
    m_st = m_st | hs;
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 3'd0, 32'h0, 2'd0, 1'b0, 4'h0, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_addr[i] = 32'h0;
    m_st = 4'h0; m_ctl = 32'h0;
    acc_valid = 0; acc_write = 0; acc_index = 0; acc_wdata = 0;
    cur_priv = 0; task_switch = 0; hit_set = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values, R9 idle rdata zero
    idle("R1");
    for (int i = 0; i < 8; i++) step(1, 0, 3'(i), 32'h0, 2'd0, 0, 4'h0, "R1");
    idle("R9");

    // R2: address slots, read back
    step(1, 1, 3'd0, 32'h1000_0000, 2'd0, 0, 4'h0, "R2");
    step(1, 1, 3'd1, 32'h2222_1111, 2'd0, 0, 4'h0, "R2");
    step(1, 1, 3'd2, 32'hDEAD_BEEF, 2'd0, 0, 4'h0, "R2");
    step(1, 1, 3'd3, 32'hFFFF_FFFC, 2'd0, 0, 4'h0, "R2");
    for (int i = 0; i < 4; i++) step(1, 0, 3'(i), 32'h0, 2'd0, 0, 4'h0, "R9");

    // R10: full control word
    step(1, 1, 3'd7, 32'hA5F0_00FF, 2'd0, 0, 4'h0, "R10");
    step(1, 0, 3'd7, 32'h0, 2'd0, 0, 4'h0, "R10");

    // R3 / R4: unprivileged accesses at every level and several indices
    for (int p = 1; p < 4; p++) begin
      step(1, 1, 3'd0, 32'h5555_5555, 2'(p), 0, 4'h0, "R4");
      step(1, 1, 3'd7, 32'h0, 2'(p), 0, 4'h0, "R4");
      step(1, 1, 3'd6, 32'hF, 2'(p), 0, 4'h0, "R4");
      step(1, 0, 3'd2, 32'h0, 2'(p), 0, 4'h0, "R3");
    end
    step(1, 0, 3'd6, 32'h0, 2'd0, 0, 4'h0, "R4");

    // R6: task switch keeps globals, then with concurrent control write
    step(0, 0, 3'd0, 32'h0, 2'd0, 1, 4'h0, "R6");
    step(1, 0, 3'd5, 32'h0, 2'd0, 0, 4'h0, "R6");
    step(1, 1, 3'd7, 32'h0000_00FF, 2'd0, 1, 4'h0, "R6");
    step(1, 0, 3'd7, 32'h0, 2'd0, 0, 4'h0, "R6");
    step(1, 1, 3'd3, 32'h0000_0040, 2'd1, 1, 4'h0, "R6");
    idle("R6");

    // R7 / R8: sticky status
    step(0, 0, 3'd0, 32'h0, 2'd0, 0, 4'b0010, "R7");
    step(0, 0, 3'd0, 32'h0, 2'd0, 0, 4'b1000, "R7");
    step(1, 0, 3'd6, 32'h0, 2'd0, 0, 4'h0, "R8");
    step(1, 1, 3'd6, 32'h0, 2'd2, 0, 4'b0001, "R8");
    step(1, 0, 3'd6, 32'h0, 2'd0, 0, 4'h0, "R8");
    step(1, 1, 3'd6, 32'hFFFF_FFF0, 2'd0, 0, 4'h0, "R8");
    step(1, 0, 3'd6, 32'h0, 2'd0, 0, 4'h0, "R8");
    step(1, 1, 3'd6, 32'h0, 2'd0, 0, 4'b0100, "R7");
    step(1, 0, 3'd6, 32'h0, 2'd0, 0, 4'h0, "R7");

    // R5: aliases
    step(1, 1, 3'd4, 32'h0000_000B, 2'd0, 0, 4'h0, "R5");
    step(1, 0, 3'd6, 32'h0, 2'd0, 0, 4'h0, "R5");
    step(1, 0, 3'd4, 32'h0, 2'd0, 0, 4'h0, "R5");
    step(1, 1, 3'd5, 32'h1234_56AA, 2'd0, 0, 4'h0, "R5");
    step(1, 0, 3'd7, 32'h0, 2'd0, 0, 4'h0, "R5");
    step(1, 0, 3'd5, 32'h0, 2'd0, 0, 4'h0, "R5");
    step(1, 1, 3'd4, 32'h0, 2'd0, 0, 4'h0, "R8");
    step(1, 0, 3'd4, 32'h0, 2'd0, 0, 4'h0, "R8");
    idle("R9");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule